// File: doc/BRIEF.md
# Single-Error-Correcting 11-Bit Packet Codec

This block has two independent paths. The encoder takes 7 data bits, named A to G, and builds an 11-bit packet from the data followed by 4 even-parity check bits. The decoder takes a received 11-bit packet and recomputes the check bits from its data field. It compares them with the received check bits to form a 4-bit syndrome. It then flips the single packet bit whose column matches that syndrome and returns the repaired 7 data bits.

Each bit of the packet has its own distinct, nonzero 4-bit column. A one-bit upset is therefore repaired wherever it lands, in the data field or in the check field. Four nonzero syndrome values belong to no column. The decoder reports these as uncorrectable and passes the received data through unchanged.

Both paths are combinational. The parameter `REGISTER_OUTPUTS` selects the output timing. At its default of 1, every output is registered once. At 0, the outputs follow the inputs directly.

Top module: `ecc11_codec`

## Requirements
- R1: The encoded packet carries the data unchanged in bits [10:4] and the check bits W, X, Y, Z in bits 3, 2, 1, 0. Data bus bit 6 is A and bit 0 is G, so packet bit 10 is A and packet bit 4 is G.
- R2: Each check bit is 1 exactly when its covered bits hold an odd count of ones. W covers A, B, C, D, E. X covers A, B, F. Y covers A, B, C, D, G.
- R3: Check bit Z covers A, C, E, F and G.
- R4: A received packet whose check bits agree with its data yields that data, with both the corrected flag and the uncorrectable flag at 0.
- R5: A packet with exactly one data bit flipped yields the original data, with the corrected flag at 1 and the uncorrectable flag at 0.
- R6: A packet with exactly one check bit flipped yields its data field unchanged, with the corrected flag at 1 and the uncorrectable flag at 0.
- R7: A syndrome (ordered W X Y Z) of 1100, 1101, 0110 or 0111 raises the uncorrectable flag and clears the corrected flag. The received data field is output unchanged.
- R8: The corrected flag and the uncorrectable flag are never 1 together.
- R9: With REGISTER_OUTPUTS = 1, every output reflects the inputs sampled at the previous rising clock edge and holds between edges.
- R10: While the active-low reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | 7 | Data to encode, bit 6 = A, bit 0 = G |
| enc_pkt_o | output | 11 | Encoded packet A..G W X Y Z, MSB first |
| dec_pkt_i | input | 11 | Received packet, same layout |
| dec_data_o | output | 7 | Repaired data |
| dec_fixed_o | output | 1 | A single-bit repair was applied |
| dec_bad_o | output | 1 | Syndrome matches no column |

## Verification
With the default setting, the encoded packet, the repaired data and both flags each arrive at the first rising edge after the inputs are presented. No result takes more than that one register. The bench changes inputs on the falling edge and samples 1 ns after the next rising edge. One latency test also samples just after a falling edge, before any rising edge, to confirm that the outputs still hold the previous result. The bench's expected values come from its own explicit parity equations and its own flip patterns.

// File: rtl/ecc11_pkg.sv
package ecc11_pkg;

    localparam int DATA_W = 7;
    localparam int CHK_W  = 4;
    localparam int PKT_W  = DATA_W + CHK_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [PKT_W-1:0]  pkt_t;

    // Registered view of every block output.
    typedef struct packed {
        pkt_t  enc_pkt;
        data_t dec_data;
        logic  fixed;
        logic  bad;
    } out_t;

    // Data bits covered by check k (k = 3 is W, down to k = 0 is Z).
    // Data bit 6 is A, bit 0 is G.
    function automatic data_t cover_mask(input int k);
        case (k)
            3:       return 7'b1111100; // W: A B C D E
            2:       return 7'b1100010; // X: A B F
            1:       return 7'b1111001; // Y: A B C D G
            default: return 7'b1010111; // Z: A C E F G
        endcase
    endfunction

    function automatic chk_t calc_checks(input data_t d);
        chk_t c;
        for (int k = 0; k < CHK_W; k++) begin
            c[k] = ^(d & cover_mask(k));
        end
        return c;
    endfunction

    // Syndrome pattern produced when packet bit pos is flipped.
    function automatic chk_t column(input int pos);
        chk_t c;
        c = '0;
        if (pos >= CHK_W) begin
            for (int k = 0; k < CHK_W; k++) begin
                c[k] = cover_mask(k)[pos-CHK_W];
            end
        end else begin
            c[pos] = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/ecc11_encoder.sv
module ecc11_encoder
    import ecc11_pkg::*;
(
    input  data_t data_i,
    output pkt_t  pkt_o
);
    chk_t checks;

    always_comb begin
        checks = calc_checks(data_i);
        pkt_o  = {data_i, checks};
    end
endmodule

// File: rtl/ecc11_syndrome.sv
module ecc11_syndrome
    import ecc11_pkg::*;
(
    input  pkt_t pkt_i,
    output chk_t syn_o
);
    data_t rx_data;
    chk_t  rx_chk;

    always_comb begin
        rx_data = pkt_i[PKT_W-1:CHK_W];
        rx_chk  = pkt_i[CHK_W-1:0];
        syn_o   = calc_checks(rx_data) ^ rx_chk;
    end
endmodule

// File: rtl/ecc11_locator.sv
module ecc11_locator
    import ecc11_pkg::*;
(
    input  chk_t syn_i,
    output pkt_t flip_o,
    output logic fixed_o,
    output logic bad_o
);
    // One comparator per packet position against its constant column.
    for (genvar pos = 0; pos < PKT_W; pos++) begin : g_col
        localparam chk_t COL = column(pos);
        assign flip_o[pos] = (syn_i == COL);
    end

    always_comb begin
        fixed_o = |flip_o;
        bad_o   = (syn_i != '0) && !fixed_o;
    end
endmodule

// File: rtl/ecc11_codec.sv
module ecc11_codec
    import ecc11_pkg::*;
#(
    parameter bit REGISTER_OUTPUTS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [PKT_W-1:0]  enc_pkt_o,
    input  logic [PKT_W-1:0]  dec_pkt_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_fixed_o,
    output logic              dec_bad_o
);
    pkt_t enc_pkt;
    chk_t syn;
    pkt_t flip;
    logic fixed;
    logic bad;
    pkt_t repaired;
    out_t out_d;
    out_t out_view;

    ecc11_encoder u_enc (
        .data_i (enc_data_i),
        .pkt_o  (enc_pkt)
    );

    ecc11_syndrome u_syn (
        .pkt_i (dec_pkt_i),
        .syn_o (syn)
    );

    ecc11_locator u_loc (
        .syn_i   (syn),
        .flip_o  (flip),
        .fixed_o (fixed),
        .bad_o   (bad)
    );

    always_comb begin
        repaired       = dec_pkt_i ^ flip;
        out_d          = '0;
        out_d.enc_pkt  = enc_pkt;
        out_d.dec_data = repaired[PKT_W-1:CHK_W];
        out_d.fixed    = fixed;
        out_d.bad      = bad;
    end

    if (REGISTER_OUTPUTS) begin : g_reg
        out_t out_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
        assign out_view = out_q;
    end else begin : g_comb
        assign out_view = rst_n ? out_d : '0;
    end

    assign enc_pkt_o   = out_view.enc_pkt;
    assign dec_data_o  = out_view.dec_data;
    assign dec_fixed_o = out_view.fixed;
    assign dec_bad_o   = out_view.bad;
endmodule

// File: rtl/ecc11_codec_chk.sv
module ecc11_codec_chk #(
    parameter bit REGISTER_OUTPUTS = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [6:0]  enc_data_i,
    input logic [10:0] enc_pkt_o,
    input logic [10:0] dec_pkt_i,
    input logic [6:0]  dec_data_o,
    input logic        dec_fixed_o,
    input logic        dec_bad_o
);
    assert_excl_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_fixed_o && dec_bad_o));

    assert_parity_w_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_pkt_o[3] == (enc_pkt_o[10] ^ enc_pkt_o[9] ^ enc_pkt_o[8] ^ enc_pkt_o[7] ^ enc_pkt_o[6]));

    assert_parity_z_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enc_pkt_o[0] == (enc_pkt_o[10] ^ enc_pkt_o[8] ^ enc_pkt_o[6] ^ enc_pkt_o[5] ^ enc_pkt_o[4]));

    if (REGISTER_OUTPUTS) begin : g_seq
        assert_enc_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> enc_pkt_o[10:4] == $past(enc_data_i));

        assert_clean_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !dec_fixed_o && !dec_bad_o) |-> dec_data_o == $past(dec_pkt_i[10:4]));

        assert_fix_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && dec_fixed_o) |-> $countones(dec_data_o ^ $past(dec_pkt_i[10:4])) <= 1);

        assert_bad_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && dec_bad_o) |-> dec_data_o == $past(dec_pkt_i[10:4]));
    end else begin : g_comb
        always_comb begin
            if (rst_n && !dec_fixed_o) begin
                assert_pass_R4: assert (dec_data_o == dec_pkt_i[10:4]);
            end
        end
    end
endmodule

bind ecc11_codec ecc11_codec_chk #(.REGISTER_OUTPUTS(REGISTER_OUTPUTS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_data_i  (enc_data_i),
    .enc_pkt_o   (enc_pkt_o),
    .dec_pkt_i   (dec_pkt_i),
    .dec_data_o  (dec_data_o),
    .dec_fixed_o (dec_fixed_o),
    .dec_bad_o   (dec_bad_o)
);

// File: tb/ecc11_codec_tb.sv
module ecc11_codec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  enc_data_i = '0;
    logic [10:0] enc_pkt_o;
    logic [10:0] dec_pkt_i = '0;
    logic [6:0]  dec_data_o;
    logic        dec_fixed_o;
    logic        dec_bad_o;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ecc11_codec #(.REGISTER_OUTPUTS(1'b1)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enc_data_i  (enc_data_i),
        .enc_pkt_o   (enc_pkt_o),
        .dec_pkt_i   (dec_pkt_i),
        .dec_data_o  (dec_data_o),
        .dec_fixed_o (dec_fixed_o),
        .dec_bad_o   (dec_bad_o)
    );

    // Reference encoder written from the parity equations (A = d[6] .. G = d[0]).
    function automatic logic [10:0] ref_enc(input logic [6:0] d);
        logic a, b, c, e, f, g, dd, w, x, y, z;
        {a, b, c, dd, e, f, g} = d;
        w = a ^ b ^ c ^ dd ^ e;
        x = a ^ b ^ f;
        y = a ^ b ^ c ^ dd ^ g;
        z = a ^ c ^ e ^ f ^ g;
        return {d, w, x, y, z};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [6:0] d, input logic [10:0] p);
        @(negedge clk);
        enc_data_i = d;
        dec_pkt_i  = p;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_dec(input string tag, input logic [6:0] ed, input logic fx, input logic bd);
        logic [10:0] act, exp;
        act = {2'b0, dec_data_o, dec_fixed_o, dec_bad_o};
        exp = {2'b0, ed, fx, bd};
        chk(act == exp, tag, act, exp);
    endtask

    task automatic test_reset();
        // R10: outputs zero under reset, even with nonzero inputs
        enc_data_i = 7'h55;
        dec_pkt_i  = 11'h7FF;
        @(posedge clk); #1;
        chk(enc_pkt_o == '0, "R10 enc reset", enc_pkt_o, '0);
        chk_dec("R10 dec reset", 7'h00, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_encode_all();
        for (int i = 0; i < 128; i++) begin
            apply(7'(i), 11'h0);
            chk(enc_pkt_o[10:4] == 7'(i), "R1 data field", enc_pkt_o, ref_enc(7'(i)));
            chk(enc_pkt_o[3:1] == ref_enc(7'(i))[3:1], "R2 W X Y", enc_pkt_o, ref_enc(7'(i)));
            chk(enc_pkt_o[0] == ref_enc(7'(i))[0], "R3 Z", enc_pkt_o, ref_enc(7'(i)));
        end
    endtask

    task automatic test_clean();
        for (int i = 0; i < 128; i++) begin
            apply(7'h0, ref_enc(7'(i)));
            chk_dec("R4 clean packet", 7'(i), 1'b0, 1'b0);
        end
    endtask

    task automatic test_data_flip();
        logic [6:0] pats [4] = '{7'h00, 7'h7F, 7'h2A, 7'h4D};
        for (int p = 0; p < 4; p++) begin
            for (int b = 4; b < 11; b++) begin
                apply(7'h0, ref_enc(pats[p]) ^ (11'h1 << b));
                chk_dec("R5 data flip", pats[p], 1'b1, 1'b0);
                chk(!(dec_fixed_o && dec_bad_o), "R8 exclusive", {9'b0, dec_fixed_o, dec_bad_o}, 11'h2);
            end
        end
    endtask

    task automatic test_check_flip();
        logic [6:0] pats [3] = '{7'h00, 7'h7F, 7'h31};
        for (int p = 0; p < 3; p++) begin
            for (int b = 0; b < 4; b++) begin
                apply(7'h0, ref_enc(pats[p]) ^ (11'h1 << b));
                chk_dec("R6 check flip", pats[p], 1'b1, 1'b0);
            end
        end
    endtask

    task automatic test_uncorrectable();
        // Flip masks on W X Y Z giving syndromes 1100, 1101, 0110, 0111.
        logic [3:0] masks [4] = '{4'b1100, 4'b1101, 4'b0110, 4'b0111};
        logic [6:0] pats [2] = '{7'h19, 7'h66};
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 4; m++) begin
                apply(7'h0, ref_enc(pats[p]) ^ {7'h0, masks[m]});
                chk_dec("R7 uncorrectable", pats[p], 1'b0, 1'b1);
                chk(!(dec_fixed_o && dec_bad_o), "R8 exclusive", {9'b0, dec_fixed_o, dec_bad_o}, 11'h1);
            end
        end
    endtask

    task automatic test_latency();
        logic [10:0] exp_pkt;
        apply(7'h12, ref_enc(7'h12));
        exp_pkt = ref_enc(7'h12);
        @(negedge clk);
        enc_data_i = 7'h6B;
        dec_pkt_i  = ref_enc(7'h6B) ^ 11'h400;
        #1;
        chk(enc_pkt_o == exp_pkt, "R9 hold before edge", enc_pkt_o, exp_pkt);
        chk_dec("R9 hold dec before edge", 7'h12, 1'b0, 1'b0);
        @(posedge clk); #1;
        chk(enc_pkt_o == ref_enc(7'h6B), "R9 update after edge", enc_pkt_o, ref_enc(7'h6B));
        chk_dec("R9 dec after edge", 7'h6B, 1'b1, 1'b0);
    endtask

    initial begin
        test_reset();
        test_encode_all();
        test_clean();
        test_data_flip();
        test_check_flip();
        test_uncorrectable();
        test_latency();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule